// File: doc/BRIEF.md
# Gray-World Auto White Balance

This block removes a colour cast from an RGB pixel stream. It needs no white reference and no settings. It uses the gray-world assumption: over a whole frame, the three colour planes should average to the same level. While a frame streams through, the block adds up the red, green and blue components of every accepted pixel. When the last pixel of the frame is accepted, the block briefly stalls the input and works out two unsigned 8.8 fixed-point gains: one for green and one for blue. Each gain is the red total divided by that channel's total, so red is the reference.

Each pixel is corrected with the gains committed before its frame began. Red passes through untouched. Green and blue are multiplied by their gains and clipped to the top code. The statistics gathered from frame N therefore correct frame N+1. That next frame may be a new capture or a replay of frame N. The previous gains stay in force until the whole new pair is ready, so no frame ever sees one new gain and one old gain.

Control is a four-state machine:

- **RUN** accepts pixels. It moves to **KICK** when the end-of-frame pixel is accepted.
- **KICK** launches both dividers and moves to **WAIT**.
- **WAIT** holds until both dividers report done, then moves to **COMMIT**.
- **COMMIT** loads the new gains, pulses `gains_ready`, and returns to **RUN**.

Top module: `grayworld_awb`

## Requirements
- R1: Per-channel sums start fresh with the accepted pixel that carries `in_sof`, include every accepted pixel up to and including the one carrying `in_eof`, and ignore cycles where `in_valid` is low.
- R2: `in_ready` drops in the cycle after the end-of-frame pixel is accepted. It stays low until `gains_ready` has pulsed, and that pulse comes no later than 40 clock cycles after the end-of-frame acceptance.
- R3: The green gain is floor(sumR*256/sumG) and the blue gain is floor(sumR*256/sumB). Both are unsigned with 8 integer and 8 fractional bits, and both saturate at 0xFFFF.
- R4: When a channel's sum is zero, that channel's gain is exactly 1.0 (0x0100).
- R5: `out_r` equals the accepted `in_r` unchanged.
- R6: `out_g` = min(255, floor(in_g*gain_g/256)), and `out_b` is computed the same way with `gain_b`.
- R7: Each accepted pixel appears on the output exactly one cycle later with `out_valid` high, in order, with `in_sof`/`in_eof` copied to `out_sof`/`out_eof`.
- R8: After reset both gains are 1.0. A frame is corrected with the gains committed before its first pixel, and the old gains stay in use until the commit.
- R9: `gains_ready` is a single-cycle pulse. The gains it announces apply from the next accepted pixel onward.
- R10: During and right after reset, `in_ready` is 1, `out_valid` is 0 and `gains_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block can take a pixel |
| in_r | input | 8 | Red component |
| in_g | input | 8 | Green component |
| in_b | input | 8 | Blue component |
| in_sof | input | 1 | Pixel is first of frame |
| in_eof | input | 1 | Pixel is last of frame |
| out_valid | output | 1 | Output pixel valid |
| out_r | output | 8 | Red, unscaled |
| out_g | output | 8 | Green, scaled and clipped |
| out_b | output | 8 | Blue, scaled and clipped |
| out_sof | output | 1 | Copied start-of-frame |
| out_eof | output | 1 | Copied end-of-frame |
| gains_ready | output | 1 | New gains committed |

## Verification
The bench feeds a chain of frames and checks each frame's output against gains derived from the frame before it:

- A uniform cast frame yields clean 2.0 and 0.5 gains.
- A replay of that frame, with one bright green pixel and idle cycles carrying garbage data, separates clipping from wrap-around and shows that non-valid cycles are left out of the sums.
- A frame with no blue exercises the zero-sum gain of 1.0.
- A bright red frame with a single green count of 1 drives the green gain into saturation.
- An all-zero-red frame drives both gains to zero.

Across the whole chain, each frame must use only the gains from its predecessor, which separates correct gain hand-over from early or late commit.

// File: rtl/awb_pkg.sv
package awb_pkg;
    localparam int GAIN_W    = 16;
    localparam int GAIN_FRAC = 8;
    localparam logic [GAIN_W-1:0] GAIN_ONE = GAIN_W'(1) << GAIN_FRAC;

    typedef enum logic [1:0] {
        ST_RUN,
        ST_KICK,
        ST_WAIT,
        ST_COMMIT
    } awb_state_e;
endpackage

// File: rtl/awb_accum.sv
module awb_accum #(
    parameter int PIX_W = 8,
    parameter int SUM_W = 27
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             restart,
    input  logic [PIX_W-1:0] pix,
    output logic [SUM_W-1:0] sum
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            sum <= '0;
        else if (en)
            sum <= restart ? SUM_W'(pix) : sum + SUM_W'(pix);
    end

    // R1: within a frame the running total never decreases
    p_sum_grows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !restart) |=> (sum >= $past(sum)));
endmodule

// File: rtl/awb_divider.sv
module awb_divider import awb_pkg::*; #(
    parameter int SUM_W = 27
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [SUM_W-1:0]  num,
    input  logic [SUM_W-1:0]  den,
    output logic              done,
    output logic [GAIN_W-1:0] gain
);
    localparam int QW = SUM_W + GAIN_FRAC;
    localparam int CW = $clog2(QW + 1);

    logic [SUM_W-1:0] rem, den_q;
    logic [QW-1:0]    quo;
    logic [CW-1:0]    cnt;
    logic             busy;
    logic [SUM_W:0]   trial, diff;
    logic             ge;
    logic             unused_top;

    always_comb begin
        trial      = {rem, quo[QW-1]};
        diff       = trial - {1'b0, den_q};
        ge         = trial >= {1'b0, den_q};
        unused_top = diff[SUM_W];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem   <= '0;
            quo   <= '0;
            den_q <= '0;
            cnt   <= '0;
            busy  <= 1'b0;
            done  <= 1'b0;
        end else if (start) begin
            rem   <= '0;
            quo   <= {num, {GAIN_FRAC{1'b0}}};
            den_q <= den;
            cnt   <= CW'(QW);
            busy  <= 1'b1;
            done  <= 1'b0;
        end else if (busy) begin
            rem <= ge ? diff[SUM_W-1:0] : trial[SUM_W-1:0];
            quo <= {quo[QW-2:0], ge};
            cnt <= cnt - 1'b1;
            if (cnt == CW'(1)) begin
                busy <= 1'b0;
                done <= 1'b1;
            end
        end else begin
            done <= 1'b0;
        end
    end

    always_comb begin
        if (den_q == '0)
            gain = GAIN_ONE;
        else if (|quo[QW-1:GAIN_W])
            gain = '1;
        else
            gain = quo[GAIN_W-1:0];
    end

    // R3: a finished division leaves a remainder below the divisor
    p_rem_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && den_q != '0) |-> (rem < den_q));
endmodule

// File: rtl/awb_scaler.sv
module awb_scaler import awb_pkg::*; #(
    parameter int PIX_W = 8
) (
    input  logic [PIX_W-1:0]  pix,
    input  logic [GAIN_W-1:0] gain,
    output logic [PIX_W-1:0]  res
);
    localparam int PW = PIX_W + GAIN_W;

    logic [PW-1:0] shifted;

    always_comb begin
        shifted = ({{GAIN_W{1'b0}}, pix} * {{PIX_W{1'b0}}, gain}) >> GAIN_FRAC;
        res     = (|shifted[PW-1:PIX_W]) ? '1 : shifted[PIX_W-1:0];
    end
endmodule

// File: rtl/grayworld_awb.sv
module grayworld_awb import awb_pkg::*; #(
    parameter int PIX_W = 8,
    parameter int MAX_W = 720,
    parameter int MAX_H = 525
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [PIX_W-1:0] in_r,
    input  logic [PIX_W-1:0] in_g,
    input  logic [PIX_W-1:0] in_b,
    input  logic             in_sof,
    input  logic             in_eof,
    output logic             out_valid,
    output logic [PIX_W-1:0] out_r,
    output logic [PIX_W-1:0] out_g,
    output logic [PIX_W-1:0] out_b,
    output logic             out_sof,
    output logic             out_eof,
    output logic             gains_ready
);
    localparam int MAX_PIX = MAX_W * MAX_H;
    localparam int SUM_W   = $clog2(MAX_PIX * ((1 << PIX_W) - 1) + 1);

    awb_state_e state_q, state_d;

    logic                         accept, div_start;
    logic [2:0][PIX_W-1:0]        chan;
    logic [2:0][SUM_W-1:0]        sums;
    logic [1:0]                   div_done;
    logic [1:0][GAIN_W-1:0]       new_gain, gain_q;
    logic [1:0][PIX_W-1:0]        scaled;

    assign accept = in_valid && in_ready;
    assign chan   = {in_b, in_g, in_r};

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_RUN;
        else
            state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:    if (accept && in_eof) state_d = ST_KICK;
            ST_KICK:   state_d = ST_WAIT;
            ST_WAIT:   if (&div_done) state_d = ST_COMMIT;
            ST_COMMIT: state_d = ST_RUN;
            default:   state_d = ST_RUN;
        endcase
    end

    // state-decoded outputs
    always_comb begin
        in_ready    = (state_q == ST_RUN);
        div_start   = (state_q == ST_KICK);
        gains_ready = (state_q == ST_COMMIT);
    end

    for (genvar c = 0; c < 3; c++) begin : g_acc
        awb_accum #(.PIX_W(PIX_W), .SUM_W(SUM_W)) u_acc (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (accept),
            .restart (in_sof),
            .pix     (chan[c]),
            .sum     (sums[c])
        );
    end

    for (genvar c = 0; c < 2; c++) begin : g_scale
        awb_divider #(.SUM_W(SUM_W)) u_div (
            .clk   (clk),
            .rst_n (rst_n),
            .start (div_start),
            .num   (sums[0]),
            .den   (sums[c+1]),
            .done  (div_done[c]),
            .gain  (new_gain[c])
        );
        awb_scaler #(.PIX_W(PIX_W)) u_sc (
            .pix  (chan[c+1]),
            .gain (gain_q[c]),
            .res  (scaled[c])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            gain_q <= {GAIN_ONE, GAIN_ONE};
        else if (state_q == ST_COMMIT)
            gain_q <= new_gain;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_r     <= '0;
            out_g     <= '0;
            out_b     <= '0;
            out_sof   <= 1'b0;
            out_eof   <= 1'b0;
        end else begin
            out_valid <= accept;
            if (accept) begin
                out_r   <= in_r;
                out_g   <= scaled[0];
                out_b   <= scaled[1];
                out_sof <= in_sof;
                out_eof <= in_eof;
            end
        end
    end

    // R2: input stalls right after the last pixel of a frame
    p_stall_after_eof_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && in_eof) |=> !in_ready);

    // R5, R7: red emerges unchanged one cycle after acceptance
    p_red_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (out_valid && out_r == $past(in_r)));

    // R8: gains only move on the commit pulse
    p_gain_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(gain_q) |-> $past(gains_ready));

    // R9: the ready flag lasts a single cycle
    p_ready_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        gains_ready |=> !gains_ready);
endmodule

// File: tb/grayworld_awb_bench.sv
module grayworld_awb_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_r = '0, in_g = '0, in_b = '0;
    logic       in_sof = 1'b0, in_eof = 1'b0;
    logic       out_valid;
    logic [7:0] out_r, out_g, out_b;
    logic       out_sof, out_eof;
    logic       gains_ready;

    int tests = 0;
    int fails = 0;
    bit ended = 1'b0;

    logic [25:0] exp_q[$];
    int unsigned mg = 256, mb = 256, pg = 256, pb = 256;
    longint sr = 0, sg = 0, sb = 0;

    always #5 clk = ~clk;

    grayworld_awb u_grayworld_awb (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_r(in_r), .in_g(in_g), .in_b(in_b),
        .in_sof(in_sof), .in_eof(in_eof),
        .out_valid(out_valid), .out_r(out_r), .out_g(out_g), .out_b(out_b),
        .out_sof(out_sof), .out_eof(out_eof),
        .gains_ready(gains_ready)
    );

    task automatic check(bit ok, string req, string what, int act, int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int unsigned calc_gain(longint num, longint den);
        longint q;
        if (den == 0) return 256;                 // R4
        q = (num * 256) / den;                    // R3
        return (q > 65535) ? 65535 : int'(q);
    endfunction

    function automatic int scale(int p, int unsigned g);
        longint v;
        v = (longint'(p) * g) >> 8;               // R6
        return (v > 255) ? 255 : int'(v);
    endfunction

    // scoreboard monitor: R5, R6, R7
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7", "unexpected output pixel", 1, 0);
            end else begin
                logic [25:0] e;
                e = exp_q.pop_front();
                check(out_r == e[25:18], "R5", "red", out_r, e[25:18]);
                check(out_g == e[17:10], "R6", "green", out_g, e[17:10]);
                check(out_b == e[9:2], "R6", "blue", out_b, e[9:2]);
                check({out_sof, out_eof} == e[1:0], "R7", "markers", {out_sof, out_eof}, e[1:0]);
            end
        end
    end

    task automatic send_px(int r, int g, int b, bit sof, bit eof, bit chk_lat);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_r = 8'(r); in_g = 8'(g); in_b = 8'(b);
        in_sof = sof; in_eof = eof; in_valid = 1'b1;
        exp_q.push_back({8'(r), 8'(scale(g, mg)), 8'(scale(b, mb)), sof, eof});
        if (sof) begin sr = r; sg = g; sb = b; end
        else begin sr += r; sg += g; sb += b; end      // R1
        if (eof) begin pg = calc_gain(sr, sg); pb = calc_gain(sr, sb); end
        @(posedge clk);
        #1 in_valid = 1'b0;
        if (chk_lat) begin
            @(negedge clk);
            check(out_valid == 1'b1, "R7", "output one cycle after accept", out_valid, 1);
        end
    endtask

    // idle cycles with garbage data: R1
    task automatic idle_garbage(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_r = 8'hFF; in_g = 8'hEE; in_b = 8'hDD;
            in_sof = 1'b1; in_eof = 1'b1;
        end
        @(negedge clk);
        in_sof = 1'b0; in_eof = 1'b0;
    endtask

    task automatic finish_frame();
        int k;
        bit seen;
        @(negedge clk);
        check(in_ready == 1'b0, "R2", "in_ready after eof", in_ready, 0);
        k = 1;
        seen = 1'b0;
        while (!seen && k < 60) begin
            @(negedge clk);
            k++;
            if (gains_ready) seen = 1'b1;
            else check(in_ready == 1'b0, "R2", "in_ready while dividing", in_ready, 0);
        end
        check(seen && k <= 40, "R2", "cycles to gains_ready", k, 40);
        mg = pg; mb = pb;                           // R8 hand-over
        @(negedge clk);
        check(gains_ready == 1'b0, "R9", "gains_ready single pulse", gains_ready, 0);
        check(in_ready == 1'b1, "R2", "in_ready after commit", in_ready, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        check(in_ready == 1'b1, "R10", "in_ready in reset", in_ready, 1);
        check(out_valid == 1'b0, "R10", "out_valid in reset", out_valid, 0);
        check(gains_ready == 1'b0, "R10", "gains_ready in reset", gains_ready, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R10", "out_valid after reset", out_valid, 0);

        // frame 1: uniform cast, unity gains (R8)
        for (int i = 0; i < 16; i++)
            send_px(100, 50, 200, i == 0, i == 15, i == 0);
        finish_frame();

        // frame 2: replay with a bright green pixel and garbage idle cycles
        for (int i = 0; i < 16; i++) begin
            if (i == 5) send_px(100, 200, 40, 1'b0, 1'b0, 1'b1);
            else        send_px(100, 50, 200, i == 0, i == 15, 1'b0);
            if (i == 8) idle_garbage(3);
        end
        finish_frame();

        // frame 3: no blue at all -> blue gain 1.0 (R4)
        for (int i = 0; i < 8; i++)
            send_px(60, 30 + i, 0, i == 0, i == 7, 1'b0);
        finish_frame();

        // frame 4: green sum of 1 -> saturated green gain (R3)
        for (int i = 0; i < 16; i++)
            send_px(255, (i == 3) ? 1 : 0, 255, i == 0, i == 15, 1'b0);
        finish_frame();

        // frame 5: apply saturated gain; red all zero
        for (int i = 0; i < 8; i++)
            send_px(0, i, i * 30, i == 0, i == 7, 1'b0);
        finish_frame();

        // frame 6: gains of zero from the red-less frame
        for (int i = 0; i < 4; i++)
            send_px(9, 10 + i, 11, i == 0, i == 3, 1'b0);
        finish_frame();

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R7", "pixels left unmatched", exp_q.size(), 0);

        if (!ended) begin
            ended = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule